// File: doc/BRIEF.md
# Switched-Capacitor Ring Controller

This block produces the cell addresses for a circular analog sample store of 64 cells that 32 channels share. A write pointer steps through the ring once every sample period (about 500 ns; `SAMPLE_DIV` clocks). On a trigger the controller builds a readout sequence that starts at the oldest cell, one past the write position. For each reading it presents a signal cell and a reference cell to the digitizer, then raises a convert request and waits for the digitizer to acknowledge.

Two write regimes are offered. In the stopped regime, the trigger halts the writer, the ring is read out, and writing resumes afterwards. In the free-running regime, writing never pauses, so there is no dead time. The reader must stay clear of the writer; if they meet, a sticky fault flag is set. Three pairings are available for readout: single cells, cell n against cell n-1, and cell n against cell n-2.

The front-end reset output is either a short strobe on every write step or a level held high, chosen by an input bit. The analog storage and the subtraction of the cell pairs are handled outside this block.

Top module: `sc_ring_ctrl`

## Requirements
- R1: After reset, the write index is 0. While writing, it advances by one every `SAMPLE_DIV` clocks and wraps from 63 to 0.
- R2: With `mode_cont`=0, a trigger taken while idle stops the writer at that edge, with no advance. The write index then holds until the readout ends, after which writing resumes.
- R3: With `mode_cont`=1, the writer keeps advancing throughout a readout.
- R4: The readout base is the write index after that edge plus one, modulo 64. Reading k uses reference cell base+k.
- R5: With `dig_mode`=0, a readout has 64 readings and the signal cell equals the reference cell.
- R6: With `dig_mode`=1, a readout has 63 readings and the signal cell is the reference cell plus one.
- R7: With `dig_mode`=2, a readout has 62 readings and the signal cell is the reference cell plus two.
- R8: `conv_req` rises two clocks after the trigger edge, with both indices already valid. It stays high until `conv_done` is sampled and falls at that edge. The next request follows after exactly one low clock.
- R9: With `mode_cont`=1, if the write index equals the signal or reference cell while `conv_req` is high, `col_err` is set at the next edge and stays set until reset. It is never set in the stopped regime.
- R10: `seq_done` is a one-clock pulse in the clock after the final `conv_done`. A trigger during a readout is ignored.
- R11: With `fe_cont`=1, `fe_rst` is held high. With `fe_cont`=0, `fe_rst` is a one-clock pulse in the clock after each write advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-domain clock |
| rst | input | 1 | Synchronous active-high chip reset |
| trig | input | 1 | Readout trigger, sampled only while idle |
| mode_cont | input | 1 | 0 = stop writing for readout, 1 = free-running write |
| dig_mode | input | 2 | 0 = single cell, 1 = n against n-1, 2 = n against n-2 |
| fe_cont | input | 1 | 0 = strobed front-end reset, 1 = held front-end reset |
| conv_done | input | 1 | Digitizer acknowledge for the current reading |
| wr_idx | output | 6 | Cell being written |
| rd_sig_idx | output | 6 | Signal cell of the current reading |
| rd_ref_idx | output | 6 | Reference cell of the current reading |
| fe_rst | output | 1 | Front-end reset |
| conv_req | output | 1 | Convert request for the current reading |
| seq_done | output | 1 | End-of-readout pulse |
| col_err | output | 1 | Sticky reader/writer collision flag |

## Verification
The assertions assume that `conv_done` arrives only while `conv_req` is high and lasts a single clock. They also assume that `mode_cont` and `dig_mode` are meaningful only at the clock where a trigger is accepted. The stimulus drives `conv_done` from a responder that watches `conv_req` and acknowledges after a programmed delay, and it changes the mode bits only in the clock that carries the trigger. A fast delay keeps the free-running reader ahead of the writer, and a delay longer than a sample period lets the writer catch up on purpose.

// File: rtl/sc_ring_pkg.sv
package sc_ring_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_SETUP = 2'd1,
    SEQ_REQ   = 2'd2
  } seq_state_e;

  localparam logic [1:0] DM_CELL = 2'd0;
  localparam logic [1:0] DM_ADJ  = 2'd1;
  localparam logic [1:0] DM_ALT  = 2'd2;

  // distance from reference cell to signal cell for a pairing mode
  function automatic logic [1:0] pair_gap(input logic [1:0] dm);
    case (dm)
      DM_ADJ:  return 2'd1;
      DM_ALT:  return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/sc_wr_pacer.sv
module sc_wr_pacer #(
  parameter int NCELLS     = 64,
  parameter int SAMPLE_DIV = 62
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic                      fe_cont,
  output logic [$clog2(NCELLS)-1:0] wr_ptr,
  output logic [$clog2(NCELLS)-1:0] wr_next,
  output logic                      fe_rst
);
  localparam int PW = $clog2(NCELLS);
  localparam int DW = $clog2(SAMPLE_DIV + 1);
  localparam logic [DW-1:0] DIV_LAST = DW'(SAMPLE_DIV - 1);

  logic [DW-1:0] div_cnt;
  logic          tick;

  always_comb begin
    tick    = wr_en && (div_cnt == DIV_LAST);
    wr_next = tick ? wr_ptr + 1'b1 : wr_ptr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt <= '0;
      wr_ptr  <= '0;
      fe_rst  <= 1'b0;
    end else begin
      if (wr_en) div_cnt <= tick ? '0 : div_cnt + 1'b1;
      wr_ptr <= wr_next;
      fe_rst <= fe_cont | tick;
    end
  end

  AST_WR_STEP: assert property (@(posedge clk) disable iff (rst)
    (wr_ptr != $past(wr_ptr)) |-> (wr_ptr == PW'($past(wr_ptr) + 1'b1))); // R1
  AST_WR_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(wr_ptr)); // R2
  AST_FE_HELD: assert property (@(posedge clk) disable iff (rst)
    fe_cont |=> fe_rst); // R11

endmodule

// File: rtl/sc_pair_gen.sv
module sc_pair_gen
  import sc_ring_pkg::*;
#(
  parameter int NCELLS = 64
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      load,
  input  logic [$clog2(NCELLS)-1:0] base,
  input  logic [$clog2(NCELLS)-1:0] k,
  input  logic [1:0]                dmode,
  output logic [$clog2(NCELLS)-1:0] rd_sig,
  output logic [$clog2(NCELLS)-1:0] rd_ref
);
  localparam int PW = $clog2(NCELLS);

  logic [PW-1:0] ref_c;

  always_comb ref_c = base + k;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_sig <= '0;
      rd_ref <= '0;
    end else if (load) begin
      rd_ref <= ref_c;
      rd_sig <= ref_c + PW'(pair_gap(dmode));
    end
  end

endmodule

// File: rtl/sc_read_seq.sv
module sc_read_seq
  import sc_ring_pkg::*;
#(
  parameter int NCELLS = 64
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      trig,
  input  logic                      mode_cont,
  input  logic [1:0]                dig_mode,
  input  logic                      conv_done,
  input  logic [$clog2(NCELLS)-1:0] wr_ptr,
  input  logic [$clog2(NCELLS)-1:0] wr_next,
  input  logic [$clog2(NCELLS)-1:0] rd_sig,
  input  logic [$clog2(NCELLS)-1:0] rd_ref,
  output logic                      accept,
  output logic                      busy,
  output logic                      cont_l,
  output logic                      load,
  output logic [$clog2(NCELLS)-1:0] base,
  output logic [$clog2(NCELLS)-1:0] k,
  output logic [1:0]                dmode_l,
  output logic                      conv_req,
  output logic                      seq_done,
  output logic                      col_err
);
  localparam int PW = $clog2(NCELLS);

  seq_state_e    state;
  logic [PW-1:0] last_k;
  logic          hit;

  always_comb begin
    accept = (state == SEQ_IDLE) && trig;
    busy   = (state != SEQ_IDLE);
    load   = (state == SEQ_SETUP);
    last_k = PW'(NCELLS - 1) - PW'(pair_gap(dmode_l));
    hit    = conv_req && cont_l && ((wr_ptr == rd_sig) || (wr_ptr == rd_ref));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SEQ_IDLE;
      base     <= '0;
      k        <= '0;
      cont_l   <= 1'b0;
      dmode_l  <= DM_CELL;
      conv_req <= 1'b0;
      seq_done <= 1'b0;
      col_err  <= 1'b0;
    end else begin
      seq_done <= 1'b0;
      if (hit) col_err <= 1'b1;
      case (state)
        SEQ_IDLE: if (trig) begin
          base    <= wr_next + 1'b1;
          k       <= '0;
          cont_l  <= mode_cont;
          dmode_l <= dig_mode;
          state   <= SEQ_SETUP;
        end
        SEQ_SETUP: begin
          conv_req <= 1'b1;
          state    <= SEQ_REQ;
        end
        SEQ_REQ: if (conv_done) begin
          conv_req <= 1'b0;
          if (k == last_k) begin
            state    <= SEQ_IDLE;
            seq_done <= 1'b1;
          end else begin
            k     <= k + 1'b1;
            state <= SEQ_SETUP;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (conv_req && !conv_done) |=> conv_req); // R8
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (rst)
    (conv_req && conv_done) |=> !conv_req); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    col_err |=> col_err); // R9
  AST_NO_ERR_STOPPED: assert property (@(posedge clk) disable iff (rst)
    (busy && !cont_l) |=> $stable(col_err)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    seq_done |=> !seq_done); // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    seq_done |-> (!busy && !conv_req)); // R10

endmodule

// File: rtl/sc_ring_ctrl.sv
module sc_ring_ctrl #(
  parameter int NCELLS     = 64,
  parameter int SAMPLE_DIV = 62
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      trig,
  input  logic                      mode_cont,
  input  logic [1:0]                dig_mode,
  input  logic                      fe_cont,
  input  logic                      conv_done,
  output logic [$clog2(NCELLS)-1:0] wr_idx,
  output logic [$clog2(NCELLS)-1:0] rd_sig_idx,
  output logic [$clog2(NCELLS)-1:0] rd_ref_idx,
  output logic                      fe_rst,
  output logic                      conv_req,
  output logic                      seq_done,
  output logic                      col_err
);
  localparam int PW = $clog2(NCELLS);

  logic          accept, busy, cont_l, load, wr_en;
  logic [PW-1:0] wr_next, base, k;
  logic [1:0]    dmode_l;

  // writer halts for a stopped-regime readout, including the trigger edge
  always_comb wr_en = !(busy && !cont_l) && !(accept && !mode_cont);

  sc_wr_pacer #(.NCELLS(NCELLS), .SAMPLE_DIV(SAMPLE_DIV)) u_pacer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .fe_cont(fe_cont),
    .wr_ptr(wr_idx), .wr_next(wr_next), .fe_rst(fe_rst)
  );

  sc_read_seq #(.NCELLS(NCELLS)) u_seq (
    .clk(clk), .rst(rst), .trig(trig), .mode_cont(mode_cont),
    .dig_mode(dig_mode), .conv_done(conv_done),
    .wr_ptr(wr_idx), .wr_next(wr_next),
    .rd_sig(rd_sig_idx), .rd_ref(rd_ref_idx),
    .accept(accept), .busy(busy), .cont_l(cont_l), .load(load),
    .base(base), .k(k), .dmode_l(dmode_l),
    .conv_req(conv_req), .seq_done(seq_done), .col_err(col_err)
  );

  sc_pair_gen #(.NCELLS(NCELLS)) u_pair (
    .clk(clk), .rst(rst), .load(load), .base(base), .k(k),
    .dmode(dmode_l), .rd_sig(rd_sig_idx), .rd_ref(rd_ref_idx)
  );

  AST_TRIG_STOPS: assert property (@(posedge clk) disable iff (rst)
    (accept && !mode_cont) |=> (wr_idx == $past(wr_idx))); // R2

endmodule

// File: tb/sc_ring_ctrl_bench.sv
`timescale 1ns/1ps
module sc_ring_ctrl_bench;
  localparam int NC  = 64;
  localparam int DIV = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trig = 1'b0, mode_cont = 1'b0, fe_cont = 1'b0, conv_done = 1'b0;
  logic [1:0] dig_mode = 2'd0;
  logic [5:0] wr_idx, rd_sig_idx, rd_ref_idx;
  logic fe_rst, conv_req, seq_done, col_err;

  int n_cmp = 0, n_bad = 0, cyc = 0, lat_cfg = 2, rcnt = 0;
  bit finished = 0;

  // reference model state
  int m_wr, m_div, m_state, m_base, m_k, m_cont, m_dm, m_sig, m_ref;
  int m_req, m_done, m_err, m_fe;

  always #4 clk = ~clk;

  sc_ring_ctrl #(.NCELLS(NC), .SAMPLE_DIV(DIV)) u_sc_ring_ctrl (
    .clk(clk), .rst(rst), .trig(trig), .mode_cont(mode_cont),
    .dig_mode(dig_mode), .fe_cont(fe_cont), .conv_done(conv_done),
    .wr_idx(wr_idx), .rd_sig_idx(rd_sig_idx), .rd_ref_idx(rd_ref_idx),
    .fe_rst(fe_rst), .conv_req(conv_req), .seq_done(seq_done), .col_err(col_err)
  );

  function automatic int gap(input int dm);
    return (dm == 1) ? 1 : (dm == 2) ? 2 : 0;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // behavioural model, stepped on every rising edge
  always @(posedge clk) begin
    int step, nwr, wen, acc;
    if (rst) begin
      m_wr = 0; m_div = 0; m_state = 0; m_base = 0; m_k = 0; m_cont = 0; m_dm = 0;
      m_sig = 0; m_ref = 0; m_req = 0; m_done = 0; m_err = 0; m_fe = 0;
    end else begin
      acc  = (m_state == 0 && trig) ? 1 : 0;
      wen  = (!(m_state != 0 && !m_cont) && !(acc && !mode_cont)) ? 1 : 0;
      step = (wen && m_div == DIV - 1) ? 1 : 0;
      nwr  = step ? (m_wr + 1) % NC : m_wr;
      m_fe = (fe_cont || step) ? 1 : 0;
      m_done = 0;
      if (m_req && m_cont && (m_wr == m_sig || m_wr == m_ref)) m_err = 1;
      case (m_state)
        0: if (trig) begin
          m_base = (nwr + 1) % NC; m_k = 0; m_cont = mode_cont; m_dm = dig_mode; m_state = 1;
        end
        1: begin
          m_ref = (m_base + m_k) % NC;
          m_sig = (m_ref + gap(m_dm)) % NC;
          m_req = 1; m_state = 2;
        end
        default: if (conv_done) begin
          m_req = 0;
          if (m_k == NC - 1 - gap(m_dm)) begin m_state = 0; m_done = 1; end
          else begin m_k++; m_state = 1; end
        end
      endcase
      if (wen) m_div = step ? 0 : m_div + 1;
      m_wr = nwr;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    string wtag, rtag;
    if (!rst && !finished) begin
      wtag = (m_state != 0 && !m_cont) ? "R2" : (m_state != 0) ? "R3" : "R1";
      rtag = (m_dm == 1) ? "R6" : (m_dm == 2) ? "R7" : "R5";
      chk(wtag, "wr_idx", int'(wr_idx), m_wr);
      chk(rtag, "rd_sig_idx", int'(rd_sig_idx), m_sig);
      chk(rtag, "rd_ref_idx", int'(rd_ref_idx), m_ref);
      chk("R8", "conv_req", int'(conv_req), m_req);
      chk("R10", "seq_done", int'(seq_done), m_done);
      chk("R9", "col_err", int'(col_err), m_err);
      chk("R11", "fe_rst", int'(fe_rst), m_fe);
    end
  end

  // digitizer responder: acknowledge after lat_cfg low-phase samples of a request
  always @(negedge clk) begin
    if (conv_req && !conv_done) begin
      rcnt++;
      if (rcnt >= lat_cfg) begin conv_done = 1'b1; rcnt = 0; end
    end else begin
      conv_done = 1'b0;
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic run_seq(input bit cont, input int dm, input int lat, input bit extra,
                         output int nread, output int ndone, output int w_start, output int w_end);
    bit prev, first;
    @(negedge clk);
    mode_cont = cont; dig_mode = 2'(dm); lat_cfg = lat; trig = 1'b1;
    w_start = int'(wr_idx);
    @(negedge clk);
    trig = 1'b0;
    nread = 0; ndone = 0; prev = 0; first = 1;
    for (int i = 0; i < 40000 && ndone == 0; i++) begin
      if (conv_req && !prev) begin
        nread++;
        if (first && !cont) chk("R4", "first rd_ref_idx", int'(rd_ref_idx), (w_start + 1) % NC);
        first = 0;
      end
      trig = (extra && nread == 10) ? 1'b1 : 1'b0;
      prev = conv_req;
      if (seq_done) ndone++;
      @(negedge clk);
    end
    trig = 1'b0;
    w_end = int'(wr_idx);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (seq_done) ndone++;
    end
  endtask

  initial begin
    int nr, nd, ws, we;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "wr_idx after reset", int'(wr_idx), 0);
    chk("R8", "conv_req after reset", int'(conv_req), 0);
    chk("R9", "col_err after reset", int'(col_err), 0);
    repeat (DIV * 70) @(negedge clk);   // wrap the ring at least once

    run_seq(1'b0, 0, 2, 1'b0, nr, nd, ws, we);
    chk("R5", "reading count", nr, 64);
    chk("R2", "writer held during stopped readout", we, ws);
    repeat (37) @(negedge clk);

    run_seq(1'b0, 1, 3, 1'b1, nr, nd, ws, we);   // extra trigger mid-readout
    chk("R6", "reading count", nr, 63);
    chk("R10", "done pulses with ignored trigger", nd, 1);
    repeat (13) @(negedge clk);

    run_seq(1'b0, 2, 1, 1'b0, nr, nd, ws, we);
    chk("R7", "reading count", nr, 62);
    chk("R9", "no fault in stopped regime", int'(col_err), 0);

    fe_cont = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      chk("R11", "held fe_rst", int'(fe_rst), 1);
    end
    fe_cont = 1'b0;
    repeat (5) @(negedge clk);

    run_seq(1'b1, 1, 1, 1'b0, nr, nd, ws, we);    // fast reader stays ahead
    chk("R6", "reading count free-running", nr, 63);
    chk("R9", "no fault with fast reader", int'(col_err), 0);
    repeat (11) @(negedge clk);

    run_seq(1'b1, 0, 20, 1'b0, nr, nd, ws, we);   // slow reader is overtaken
    chk("R3", "writer moved during free-running readout", (we != ws) ? 1 : 0, 1);
    chk("R9", "fault after overtake", int'(col_err), 1);
    repeat (50) @(negedge clk);
    chk("R9", "fault sticky", int'(col_err), 1);

    finished = 1;
    summary();
    $finish;
  end
endmodule